// File: doc/BRIEF.md
# Configuration Cycle Address Router

This block sits in a host bridge and turns a latched configuration address into one routed configuration cycle. Software writes a 32-bit address word through a small register port. It also writes the secondary and subordinate bus numbers of the downstream link through the same port. When a configuration data access is requested, the block decodes the stored word. It then picks one destination: one of the bridge's own functions, the upstream hub link, or the downstream link. It also picks the cycle type, and for a downstream Type 0 cycle it produces a one-hot device-select vector.

The decision is registered and presented as one dispatch beat. The beat is held with a valid flag until the consumer signals done. Requests that arrive while a beat is held are ignored. Requests that decode to nothing are dropped without a beat. These are requests made while configuration is disabled, or requests to an internal function other than function 0.

Top module: `cfg_route_top`

## Requirements
- R1: After reset, `cyc_valid` is 0 and all three registers (address, secondary, subordinate) read back as 0.
- R2: Register select 0 is the address word, 1 the secondary bus (bits 7:0), 2 the subordinate bus (bits 7:0), and 3 reads 0 and ignores writes. A write takes effect at the clock edge. In the address word, bits 30:24 and 1:0 ignore writes and read 0. Bit 31, bits 23:16 (bus), 15:11 (device), 10:8 (function) and 7:2 (register) store what is written.
- R3: With address bit 31 clear, a request produces no beat.
- R4: Bus 0 with device 0 or 1 and function 0 dispatches with target code 0 (internal), `cyc_type1`=0, no device select.
- R5: Bus 0 with device 0 or 1 and a non-zero function produces no beat.
- R6: Bus 0 with device 2 or above dispatches with target code 1 (hub), `cyc_type1`=0.
- R7: A non-zero bus equal to the secondary register dispatches with target code 2 (downstream) and `cyc_type1`=0. For device d below 16, `cyc_idsel` has only bit d set; that is address line 16+d.
- R8: In the case of R7 with device 16 or above, `cyc_idsel` is 0 and `cyc_mabort` is 1. In every other beat `cyc_mabort` is 0.
- R9: A non-zero bus greater than the secondary and at most the subordinate dispatches with target code 2 and `cyc_type1`=1, with no device select.
- R10: Any other non-zero bus dispatches with target code 1 and `cyc_type1`=1.
- R11: Each beat carries `cyc_bus` equal to the bus field. It carries `cyc_addr` with device in bits 15:11, function in 10:8, register in 7:2, and 0 in bits 1:0.
- R12: A request seen at an edge while no beat is held is decoded from the address value before that edge, and the beat is valid after that edge. The beat's fields stay unchanged until an edge with `cyc_done` high, after which `cyc_valid` is 0. Requests while a beat is held are ignored.
- R13: While secondary and subordinate are both 0, no non-zero bus is routed downstream; it goes to the hub as Type 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 secondary, 2 subordinate |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| cyc_req | input | 1 | Configuration data access request |
| cyc_done | input | 1 | Consumer has taken the held beat |
| cyc_valid | output | 1 | A dispatch beat is held |
| cyc_target | output | 2 | 0 internal, 1 hub link, 2 downstream link |
| cyc_type1 | output | 1 | 1 for a Type 1 cycle |
| cyc_idsel | output | 16 | One-hot device select, bit i is address line 16+i |
| cyc_mabort | output | 1 | Downstream Type 0 with no device selected |
| cyc_bus | output | 8 | Bus number of the beat |
| cyc_addr | output | 16 | Forwarded device, function and register fields |

## Verification
A wrong range comparison or a stale secondary or subordinate value shows up as a wrong `cyc_target` or `cyc_type1`. It appears on the first beat whose bus lies near a range boundary, one edge after the request. A corrupted address register field shows at `reg_rdata` in the same cycle and in `cyc_addr`/`cyc_bus` of the next beat. A wrong held-beat state shows within one edge, as a beat that changes, fails to drop after done, or re-arms during a hold. The bench's reference model compares every output on every clock, so any of these is reported in the cycle it first appears.

// File: rtl/cfg_route_pkg.sv
// Shared field positions, widths and types for the configuration router.
// Assumes the conventional 32-bit configuration address word layout.
package cfg_route_pkg;
    localparam int ADDR_W  = 32;
    localparam int BUS_W   = 8;
    localparam int DEV_W   = 5;
    localparam int FN_W    = 3;
    localparam int REGN_W  = 6;
    localparam int IDSEL_N = 16;

    localparam int EN_BIT  = ADDR_W - 1;
    localparam int REG_LO  = 2;
    localparam int FN_LO   = REG_LO + REGN_W;
    localparam int DEV_LO  = FN_LO + FN_W;
    localparam int BUS_LO  = DEV_LO + DEV_W;
    localparam int FWD_W   = DEV_LO + DEV_W;

    localparam logic [ADDR_W-1:0] FIELD_MASK =
        ((ADDR_W'(1) << (BUS_W + DEV_W + FN_W + REGN_W)) - ADDR_W'(1)) << REG_LO;
    localparam logic [ADDR_W-1:0] ADDR_MASK = (ADDR_W'(1) << EN_BIT) | FIELD_MASK;

    typedef enum logic [1:0] {
        TGT_INT = 2'd0,
        TGT_HUB = 2'd1,
        TGT_DN  = 2'd2
    } tgt_e;

    typedef struct packed {
        logic               go;
        tgt_e               tgt;
        logic               type1;
        logic [IDSEL_N-1:0] idsel;
        logic               mabort;
        logic [BUS_W-1:0]   bus;
        logic [FWD_W-1:0]   fwd;
    } route_s;
endpackage

// File: rtl/cfg_addr_reg.sv
// Address, secondary-bus and subordinate-bus registers with a read mux.
// Assumes one register access per cycle; reserved address bits are never stored.
module cfg_addr_reg
    import cfg_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        sel,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] addr_q,
    output logic [BUS_W-1:0]  sec_q,
    output logic [BUS_W-1:0]  sub_q,
    output logic [ADDR_W-1:0] rdata
);
    // Register update on write strobe; reserved address bits forced to 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            sec_q  <= '0;
            sub_q  <= '0;
        end else if (wr) begin
            case (sel)
                2'd0:    addr_q <= wdata & ADDR_MASK;
                2'd1:    sec_q  <= wdata[BUS_W-1:0];
                2'd2:    sub_q  <= wdata[BUS_W-1:0];
                default: ;
            endcase
        end
    end

    // Read mux of the selected register.
    always_comb begin
        case (sel)
            2'd0:    rdata = addr_q;
            2'd1:    rdata = ADDR_W'(sec_q);
            2'd2:    rdata = ADDR_W'(sub_q);
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/cfg_decode.sv
// Combinational route decision for the latched configuration address.
// Assumes the internal functions occupy device numbers 0..NUM_INT_DEV-1 on bus 0.
module cfg_decode
    import cfg_route_pkg::*;
#(
    parameter int NUM_INT_DEV = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  sec,
    input  logic [BUS_W-1:0]  sub,
    output route_s            route
);
    logic              en;
    logic [BUS_W-1:0]  bus;
    logic [DEV_W-1:0]  dev;
    logic [FN_W-1:0]   fn;
    logic [IDSEL_N-1:0] idsel_dec;
    logic              dev_hi;
    logic              dev_int;
    logic              in_range;
    logic              unused_bits;

    assign en          = addr[EN_BIT];
    assign bus         = addr[BUS_LO +: BUS_W];
    assign dev         = addr[DEV_LO +: DEV_W];
    assign fn          = addr[FN_LO +: FN_W];
    assign unused_bits = ^{addr[EN_BIT-1:BUS_LO+BUS_W], addr[REG_LO-1:0]};

    // One comparator per select line; devices past the table match none.
    for (genvar i = 0; i < IDSEL_N; i++) begin : g_idsel
        assign idsel_dec[i] = (dev == DEV_W'(i));
    end

    assign dev_hi   = (32'(dev) >= IDSEL_N);
    assign dev_int  = (32'(dev) < NUM_INT_DEV);
    assign in_range = (bus > sec) && (bus <= sub);

    // Priority route selection: enable, bus 0, secondary match, range, else hub.
    always_comb begin
        route       = '0;
        route.tgt   = TGT_INT;
        route.bus   = bus;
        route.fwd   = {addr[FWD_W-1:REG_LO], {REG_LO{1'b0}}};
        if (!en) begin
            route.go = 1'b0;
        end else if (bus == '0) begin
            if (dev_int) begin
                route.go  = (fn == '0);
                route.tgt = TGT_INT;
            end else begin
                route.go  = 1'b1;
                route.tgt = TGT_HUB;
            end
        end else if (bus == sec) begin
            route.go     = 1'b1;
            route.tgt    = TGT_DN;
            route.idsel  = idsel_dec;
            route.mabort = dev_hi;
        end else if (in_range) begin
            route.go    = 1'b1;
            route.tgt   = TGT_DN;
            route.type1 = 1'b1;
        end else begin
            route.go    = 1'b1;
            route.tgt   = TGT_HUB;
            route.type1 = 1'b1;
        end
    end
endmodule

// File: rtl/cfg_dispatch.sv
// Holds one registered dispatch beat until the consumer signals done.
// Assumes done is only meaningful while a beat is held.
module cfg_dispatch
    import cfg_route_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req,
    input  logic   done,
    input  route_s route,
    output logic   valid_q,
    output route_s beat_q
);
    logic accept;

    assign accept = req && !valid_q && route.go;

    // Valid flag: set on an accepted request, cleared by done.
    always_ff @(posedge clk) begin
        if (!rst_n)               valid_q <= 1'b0;
        else if (valid_q && done) valid_q <= 1'b0;
        else if (accept)          valid_q <= 1'b1;
    end

    // Beat capture: fields load only when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)      beat_q <= '0;
        else if (accept) beat_q <= route;
    end
endmodule

// File: rtl/cfg_route_top.sv
// Configuration cycle router: address registers, decoder and dispatch holder.
// Assumes a request decodes the address value stored before its clock edge.
module cfg_route_top
    import cfg_route_pkg::*;
#(
    parameter int NUM_INT_DEV = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [1:0]          reg_sel,
    input  logic [ADDR_W-1:0]   reg_wdata,
    output logic [ADDR_W-1:0]   reg_rdata,
    input  logic                cyc_req,
    input  logic                cyc_done,
    output logic                cyc_valid,
    output logic [1:0]          cyc_target,
    output logic                cyc_type1,
    output logic [IDSEL_N-1:0]  cyc_idsel,
    output logic                cyc_mabort,
    output logic [BUS_W-1:0]    cyc_bus,
    output logic [FWD_W-1:0]    cyc_addr
);
    logic [ADDR_W-1:0] addr_q;
    logic [BUS_W-1:0]  sec_q;
    logic [BUS_W-1:0]  sub_q;
    route_s            route;
    route_s            beat_q;
    logic              unused_go;

    cfg_addr_reg u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .sel    (reg_sel),
        .wdata  (reg_wdata),
        .addr_q (addr_q),
        .sec_q  (sec_q),
        .sub_q  (sub_q),
        .rdata  (reg_rdata)
    );

    cfg_decode #(.NUM_INT_DEV(NUM_INT_DEV)) u_dec (
        .addr  (addr_q),
        .sec   (sec_q),
        .sub   (sub_q),
        .route (route)
    );

    cfg_dispatch u_disp (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (cyc_req),
        .done    (cyc_done),
        .route   (route),
        .valid_q (cyc_valid),
        .beat_q  (beat_q)
    );

    assign cyc_target = beat_q.tgt;
    assign cyc_type1  = beat_q.type1;
    assign cyc_idsel  = beat_q.idsel;
    assign cyc_mabort = beat_q.mabort;
    assign cyc_bus    = beat_q.bus;
    assign cyc_addr   = beat_q.fwd;
    assign unused_go  = beat_q.go;
endmodule

// File: rtl/cfg_route_chk.sv
// Protocol and encoding checks on the router's ports, bound to the top.
// Assumes it sees the enable bit of the stored address word.
module cfg_route_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  reg_sel,
    input logic [31:0] reg_rdata,
    input logic        cyc_req,
    input logic        cyc_done,
    input logic        cyc_valid,
    input logic [1:0]  cyc_target,
    input logic        cyc_type1,
    input logic [15:0] cyc_idsel,
    input logic        cyc_mabort,
    input logic [7:0]  cyc_bus,
    input logic [15:0] cyc_addr,
    input logic        cfg_en
);
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd0) |-> (reg_rdata[30:24] == 7'd0 && reg_rdata[1:0] == 2'd0));

    a_r3_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cyc_valid) |-> ($past(cyc_req) && $past(cfg_en)));

    a_r4_internal_bus0: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_target == 2'd0) |->
        (cyc_bus == 8'd0 && cyc_addr[10:8] == 3'd0 && cyc_addr[15:12] == 4'd0 && !cyc_type1));

    a_r7_idsel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |-> $onehot0(cyc_idsel));

    a_r7_idsel_downstream: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_idsel != 16'd0) |-> (cyc_target == 2'd2 && !cyc_type1));

    a_r8_mabort_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_mabort) |-> (cyc_idsel == 16'd0 && cyc_target == 2'd2 && !cyc_type1));

    a_r9_type1_no_idsel: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_type1) |-> (cyc_idsel == 16'd0 && !cyc_mabort));

    a_r11_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |-> (cyc_addr[1:0] == 2'd0));

    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && !cyc_done) |=> (cyc_valid && $stable(cyc_target) && $stable(cyc_type1)
            && $stable(cyc_idsel) && $stable(cyc_mabort) && $stable(cyc_bus) && $stable(cyc_addr)));

    a_r12_release: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_done) |=> !cyc_valid);
endmodule

bind cfg_route_top cfg_route_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_sel    (reg_sel),
    .reg_rdata  (reg_rdata),
    .cyc_req    (cyc_req),
    .cyc_done   (cyc_done),
    .cyc_valid  (cyc_valid),
    .cyc_target (cyc_target),
    .cyc_type1  (cyc_type1),
    .cyc_idsel  (cyc_idsel),
    .cyc_mabort (cyc_mabort),
    .cyc_bus    (cyc_bus),
    .cyc_addr   (cyc_addr),
    .cfg_en     (addr_q[31])
);

// File: tb/cfg_route_top_tb.sv
// Bench: behavioural reference model stepped on every clock and compared
// with every output, plus directed per-requirement checks.
module cfg_route_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        cyc_req = 1'b0;
    logic        cyc_done = 1'b0;
    logic        cyc_valid;
    logic [1:0]  cyc_target;
    logic        cyc_type1;
    logic [15:0] cyc_idsel;
    logic        cyc_mabort;
    logic [7:0]  cyc_bus;
    logic [15:0] cyc_addr;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cfg_route_top u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cyc_req(cyc_req),
        .cyc_done(cyc_done), .cyc_valid(cyc_valid), .cyc_target(cyc_target),
        .cyc_type1(cyc_type1), .cyc_idsel(cyc_idsel), .cyc_mabort(cyc_mabort),
        .cyc_bus(cyc_bus), .cyc_addr(cyc_addr)
    );

    // Reference model state.
    logic [31:0] m_addr = 32'd0;
    int          m_sec = 0, m_sub = 0;
    bit          m_valid = 1'b0;
    int          m_tgt = 0;
    bit          m_t1 = 1'b0, m_ma = 1'b0;
    logic [15:0] m_idsel = 16'd0;
    int          m_bus = 0;
    logic [15:0] m_fwd = 16'd0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] mk(input bit en, input int bus, input int dev, input int fn, input int rg);
        return {en, 7'd0, 8'(bus), 5'(dev), 3'(fn), 6'(rg), 2'd0};
    endfunction

    function automatic logic [31:0] model_read(input logic [1:0] s);
        case (s)
            2'd0:    return m_addr;
            2'd1:    return 32'(m_sec);
            2'd2:    return 32'(m_sub);
            default: return 32'd0;
        endcase
    endfunction

    // Advance the model from the inputs seen at this edge.
    task automatic model_step();
        int bus, dev, fn;
        bit go;
        if (!rst_n) begin
            m_addr = 0; m_sec = 0; m_sub = 0; m_valid = 0;
            m_tgt = 0; m_t1 = 0; m_ma = 0; m_idsel = 0; m_bus = 0; m_fwd = 0;
            return;
        end
        if (m_valid) begin
            if (cyc_done) m_valid = 0;
        end else if (cyc_req) begin
            bus = int'(m_addr[23:16]);
            dev = int'(m_addr[15:11]);
            fn  = int'(m_addr[10:8]);
            go = m_addr[31];
            if (go) begin
                m_idsel = 0; m_ma = 0; m_t1 = 0;
                if (bus == 0) begin
                    if (dev <= 1) begin m_tgt = 0; go = (fn == 0); end
                    else m_tgt = 1;
                end else if (bus == m_sec) begin
                    m_tgt = 2;
                    if (dev < 16) m_idsel = 16'(1 << dev);
                    else m_ma = 1;
                end else if (bus > m_sec && bus <= m_sub) begin
                    m_tgt = 2; m_t1 = 1;
                end else begin
                    m_tgt = 1; m_t1 = 1;
                end
                if (go) begin
                    m_valid = 1;
                    m_bus = bus;
                    m_fwd = {m_addr[15:2], 2'b00};
                end
            end
        end
        if (reg_wr) begin
            case (reg_sel)
                2'd0: m_addr = reg_wdata & 32'h80FF_FFFC;
                2'd1: m_sec = int'(reg_wdata[7:0]);
                2'd2: m_sub = int'(reg_wdata[7:0]);
                default: ;
            endcase
        end
    endtask

    // Compare every output against the model, well after the edge.
    task automatic compare();
        string tag;
        chk(reg_rdata == model_read(reg_sel), "R2 readback", reg_rdata, model_read(reg_sel));
        chk(cyc_valid == m_valid, "R12 valid", 32'(cyc_valid), 32'(m_valid));
        if (m_valid && cyc_valid) begin
            if (m_tgt == 0) tag = "R4";
            else if (m_tgt == 1) tag = m_t1 ? "R10" : "R6";
            else if (m_t1) tag = "R9";
            else tag = m_ma ? "R8" : "R7";
            chk(32'(cyc_target) == 32'(m_tgt), {tag, " target"}, 32'(cyc_target), 32'(m_tgt));
            chk(cyc_type1 == m_t1, {tag, " type"}, 32'(cyc_type1), 32'(m_t1));
            chk(cyc_idsel == m_idsel, {tag, " idsel"}, 32'(cyc_idsel), 32'(m_idsel));
            chk(cyc_mabort == m_ma, {tag, " mabort"}, 32'(cyc_mabort), 32'(m_ma));
            chk(32'(cyc_bus) == 32'(m_bus), "R11 bus", 32'(cyc_bus), 32'(m_bus));
            chk(cyc_addr == m_fwd, "R11 addr", 32'(cyc_addr), 32'(m_fwd));
        end
    endtask

    always @(posedge clk) begin
        model_step();
        #3;
        if (!finished) compare();
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_sel = 2'd0; reg_wdata = 32'd0;
    endtask

    // Load an address, request once, hold, re-request mid-hold, then release.
    task automatic run(input logic [31:0] a, input int hold, input bit exp_go, input string tag);
        wr(2'd0, a);
        cyc_req = 1'b1;
        tick();
        cyc_req = 1'b0;
        chk(cyc_valid == exp_go, {tag, " dispatch"}, 32'(cyc_valid), 32'(exp_go));
        for (int k = 0; k < hold; k++) begin
            if (k == 1) cyc_req = 1'b1;
            tick();
            cyc_req = 1'b0;
        end
        if (hold > 1) chk(cyc_valid == exp_go, "R12 held", 32'(cyc_valid), 32'(exp_go));
        cyc_done = 1'b1;
        tick();
        cyc_done = 1'b0;
        chk(cyc_valid == 1'b0, "R12 release", 32'(cyc_valid), 32'd0);
        tick();
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        // R1: reset state of the registers and the beat.
        for (int s = 0; s < 3; s++) begin
            reg_sel = 2'(s);
            #1;
            chk(reg_rdata == 32'd0, "R1 reg reset", reg_rdata, 32'd0);
        end
        reg_sel = 2'd0;
        chk(cyc_valid == 1'b0, "R1 valid reset", 32'(cyc_valid), 32'd0);
        tick();

        // R2: reserved bits dropped, select 3 ignored.
        wr(2'd0, 32'hFFFF_FFFF);
        #1;
        chk(reg_rdata == 32'h80FF_FFFC, "R2 addr mask", reg_rdata, 32'h80FF_FFFC);
        wr(2'd3, 32'hFFFF_FFFF);
        reg_sel = 2'd3;
        #1;
        chk(reg_rdata == 32'd0, "R2 sel3", reg_rdata, 32'd0);
        reg_sel = 2'd0;
        tick();

        // R13: with both bus registers 0, a non-zero bus goes to the hub as Type 1.
        run(mk(1, 3, 0, 0, 5), 2, 1'b1, "R13");
        chk(cyc_valid == 1'b0, "R13 after", 32'(cyc_valid), 32'd0);

        wr(2'd1, 32'd2);
        wr(2'd2, 32'd5);

        run(mk(0, 2, 1, 0, 3), 2, 1'b0, "R3");
        run(mk(1, 0, 0, 0, 9), 3, 1'b1, "R4");
        run(mk(1, 0, 1, 0, 63), 0, 1'b1, "R4");
        run(mk(1, 0, 1, 3, 4), 2, 1'b0, "R5");
        run(mk(1, 0, 0, 7, 4), 1, 1'b0, "R5");
        run(mk(1, 0, 2, 0, 1), 2, 1'b1, "R6");
        run(mk(1, 0, 31, 5, 12), 1, 1'b1, "R6");
        for (int d = 0; d < 32; d++) begin
            run(mk(1, 2, d, d % 8, d), d % 3, 1'b1, d < 16 ? "R7" : "R8");
        end
        run(mk(1, 3, 4, 1, 2), 2, 1'b1, "R9");
        run(mk(1, 5, 9, 2, 7), 1, 1'b1, "R9");
        run(mk(1, 6, 0, 0, 0), 2, 1'b1, "R10");
        run(mk(1, 1, 3, 0, 0), 1, 1'b1, "R10");
        run(mk(1, 255, 17, 6, 44), 2, 1'b1, "R11");

        // R12: back-to-back write and request decode the old address value.
        wr(2'd0, mk(1, 0, 5, 0, 0));
        reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = mk(0, 0, 5, 0, 0);
        cyc_req = 1'b1;
        tick();
        reg_wr = 1'b0; cyc_req = 1'b0; reg_wdata = 32'd0;
        chk(cyc_valid == 1'b1, "R12 old value", 32'(cyc_valid), 32'd1);
        chk(32'(cyc_target) == 32'd1, "R12 target", 32'(cyc_target), 32'd1);
        cyc_done = 1'b1;
        tick();
        cyc_done = 1'b0;
        repeat (2) tick();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R12 watchdog expired actual=hung expected=finished");
            finish_run();
        end
    end
endmodule